// File: doc/BRIEF.md
# Two-Wire Bus Target Receiver

This block is the receive side of a target on a two-wire serial bus. It runs from the system clock. It passes the clock and data lines through a synchroniser and finds their edges by oversampling. From those edges it recognises bus start and stop conditions and shifts in the address byte, most significant bit first. It then decides whether to answer.

The block answers in two cases. The first is its own programmable address. The second, when that option is enabled, is the broadcast address combined with a write. It answers by raising an open-drain pull-down enable during the acknowledge slot. A busy input turns any answer into a not-acknowledge. The block refuses the reserved upper address range in all cases.

After a write address is acknowledged, each received byte appears on a data bus together with a one-cycle strobe, and the block acknowledges it. A read address is acknowledged, then the line is released. After a not-acknowledge, the block ignores the bus until the next start or stop condition.

Top module: `wire_target_rx`

## Requirements
- R1: A start condition (data falls while clock is high), including a repeated start in mid-transfer, returns the block to address reception, releases the line and clears both match flags.
- R2: Address bits are sampled on rising clock edges, most significant first: seven address bits, then a direction bit (1 = read, 0 = write).
- R3: On a match, `sda_pull` goes high at the falling clock edge that ends the eighth bit and returns low at the falling edge that ends the ninth (acknowledge) pulse.
- R4: Addresses whose top four bits are 1111 never match as the own address, and an own address of 0000000 never matches as the own address.
- R5: Address 0000000 is acknowledged only when `gc_enable` is high and the direction bit is 0. With a direction bit of 1 it is never acknowledged.
- R6: If `busy` is high when an acknowledge is decided, for either an address or a data byte, the block gives a not-acknowledge and leaves `sda_pull` low.
- R7: After a write address is acknowledged, each 8-bit data byte appears on `rx_data` with a one-cycle `rx_valid` pulse, and the byte is acknowledged.
- R8: An own-address read is acknowledged, after which the line stays released and no data is presented.
- R9: After any not-acknowledge, the block neither pulls the line nor strobes `rx_valid` until the next start or stop.
- R10: An accepted address sets `addressed`. `addressed_gc` is 1 when the accepted address was the broadcast address and 0 when it was the own address.
- R11: A stop condition (data rises while clock is high) releases the line, clears both flags and returns to idle. Reset leaves all outputs at 0.
- R12: Every output responds in the third system clock after the bus edge that causes it (two synchroniser stages plus one edge register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| own_addr | input | ADDR_W | Own target address |
| gc_enable | input | 1 | Accept broadcast address with write |
| busy | input | 1 | Force not-acknowledge |
| sda_pull | output | 1 | Open-drain enable: 1 drives data low |
| rx_data | output | ADDR_W+1 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| addressed | output | 1 | Target selected since last start |
| addressed_gc | output | 1 | Selection was the broadcast address |

## Verification
The assertions assume that the bus lines move far more slowly than the system clock. They also assume that data changes only while the clock line is low, except when forming start and stop conditions. Finally, they assume that `busy` and `own_addr` stay stable around the falling clock edge where an acknowledge is decided. The stimulus holds each bus phase for six system clocks. It waits two clocks after each clock fall before moving data, and it changes `busy` and the configuration only between bytes. Together these keep every edge clear of the synchroniser's window and every decision on a settled input.

// File: rtl/wtr_pkg.sv
package wtr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } wtr_state_t;
endpackage

// File: rtl/wtr_line_sync.sv
module wtr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_s, sda_s, scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= scl_in;
          sda_p <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= {scl_p[STAGES-2:0], scl_in};
          sda_p <= {sda_p[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_lvl   = sda_s;
endmodule

// File: rtl/wtr_bit_shift.sv
module wtr_bit_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         sample,
  input  logic         bit_in,
  output logic [W-1:0] word,
  output logic         full
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(W));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      word <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en && sample && !full) begin
      word <= {word[W-2:0], bit_in};
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wtr_addr_match.sv
module wtr_addr_match #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] own_addr,
  input  logic          rw,
  input  logic          gc_en,
  output logic          own_hit,
  output logic          gc_hit
);
  localparam int RSV_W = 4;
  logic rsv, zero;

  assign rsv     = &addr[AW-1:AW-RSV_W];
  assign zero    = (addr == '0);
  assign own_hit = (addr == own_addr) && !rsv && !zero;
  assign gc_hit  = gc_en && zero && !rw;
endmodule

// File: rtl/wire_target_rx.sv
module wire_target_rx
  import wtr_pkg::*;
#(
  parameter  int ADDR_W      = 7,
  parameter  int SYNC_STAGES = 2,
  localparam int BYTE_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_enable,
  input  logic              busy,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              addressed,
  output logic              addressed_gc
);
  wtr_state_t st;
  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic [BYTE_W-1:0] frame_word;
  logic frame_full, frame_clr, frame_en;
  logic own_hit, gc_hit, accept, rw_q;

  wtr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl)
  );

  assign frame_clr = start_det || (scl_fall && (st == ST_AACK || st == ST_DACK));
  assign frame_en  = (st == ST_ADDR) || (st == ST_DATA);

  wtr_bit_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clr(frame_clr), .shift_en(frame_en),
    .sample(scl_rise), .bit_in(sda_lvl), .word(frame_word), .full(frame_full)
  );

  wtr_addr_match #(.AW(ADDR_W)) u_match (
    .addr(frame_word[BYTE_W-1:1]), .own_addr(own_addr), .rw(frame_word[0]),
    .gc_en(gc_enable), .own_hit(own_hit), .gc_hit(gc_hit)
  );

  assign accept = (own_hit || gc_hit) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      sda_pull     <= 1'b0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      addressed    <= 1'b0;
      addressed_gc <= 1'b0;
      rw_q         <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start_det) begin
        st           <= ST_ADDR;
        sda_pull     <= 1'b0;
        addressed    <= 1'b0;
        addressed_gc <= 1'b0;
      end else if (stop_det) begin
        st           <= ST_IDLE;
        sda_pull     <= 1'b0;
        addressed    <= 1'b0;
        addressed_gc <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_fall && frame_full) begin
            if (accept) begin
              sda_pull     <= 1'b1;
              addressed    <= 1'b1;
              addressed_gc <= gc_hit;
              rw_q         <= frame_word[0];
              st           <= ST_AACK;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_AACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= rw_q ? ST_SKIP : ST_DATA;
          end
          ST_DATA: if (scl_fall && frame_full) begin
            if (!busy) begin
              sda_pull <= 1'b1;
              rx_data  <= frame_word;
              rx_valid <= 1'b1;
              st       <= ST_DACK;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_DACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  assert_pull_in_ack_R3: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> (st == ST_AACK || st == ST_DACK));
  assert_start_release_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!sda_pull && !addressed && st == ST_ADDR));
  assert_stop_idle_R11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_pull && !addressed && !addressed_gc && st == ST_IDLE));
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_gc_flag_R10: assert property (@(posedge clk) disable iff (rst)
    addressed_gc |-> addressed);
  assert_busy_nack_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && scl_fall && frame_full && (st == ST_ADDR || st == ST_DATA)) |=> !sda_pull);
  assert_gc_read_refused_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && scl_fall && frame_full &&
     frame_word[BYTE_W-1:1] == '0 && frame_word[0]) |=> !sda_pull);
  assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> (!sda_pull && !rx_valid));
endmodule

// File: tb/wire_target_rx_test.sv
module wire_target_rx_test;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [6:0] own = 7'h2D;
  logic gc_en = 1'b0, busy = 1'b0;
  logic sda_pull, rx_valid, addressed, addressed_gc;
  logic [7:0] rx_data;
  logic sda_bus;

  int checks = 0, errs = 0, cyc = 0, vcount = 0;

  // behavioural model state
  int   m_phase = 0;   // 0 none, 1 address, 2 data
  bit   m_rw = 0, m_ack = 0;
  logic e_pull = 0, e_valid = 0, e_sel = 0, e_gc = 0;
  logic [7:0] e_data = 0;
  logic [11:0] d1, d2, d3;

  assign sda_bus = sda_drv & ~sda_pull;

  wire_target_rx uut (
    .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_bus),
    .own_addr(own), .gc_enable(gc_en), .busy(busy),
    .sda_pull(sda_pull), .rx_data(rx_data), .rx_valid(rx_valid),
    .addressed(addressed), .addressed_gc(addressed_gc)
  );

  always #5 clk = ~clk;

  // R12: three-cycle latency from bus edge to outputs
  always @(posedge clk) begin
    if (rst) begin
      d1 <= '0; d2 <= '0; d3 <= '0;
    end else begin
      d1 <= {e_pull, e_valid, e_sel, e_gc, e_data};
      d2 <= d1;
      d3 <= d2;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R12 sda_pull", sda_pull, d3[11]);
      chk("R7 rx_valid", rx_valid, d3[10]);
      chk("R10 addressed", addressed, d3[9]);
      chk("R10 addressed_gc", addressed_gc, d3[8]);
      if (d3[10]) chk("R7 rx_data", rx_data, d3[7:0]);
    end
  end

  always @(posedge clk) begin
    if (rx_valid) vcount++;
    cyc++;
    if (cyc > 60000) begin
      errs++;
      $display("FAIL R11 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      e_valid = 0;
    end
  endtask

  task automatic m_start();
    m_phase = 1; m_ack = 0; e_pull = 0; e_sel = 0; e_gc = 0;
  endtask

  task automatic m_stop();
    m_phase = 0; m_ack = 0; e_pull = 0; e_sel = 0; e_gc = 0;
  endtask

  task automatic m_byte_end(input logic [7:0] b);
    bit own_ok, gc_ok;
    m_ack = 0;
    if (m_phase == 1) begin
      own_ok = (b[7:1] == own) && (b[7:4] != 4'hF) && (b[7:1] != 7'h00);
      gc_ok  = gc_en && (b[7:1] == 7'h00) && !b[0];
      if ((own_ok || gc_ok) && !busy) begin
        m_ack = 1; e_pull = 1; e_sel = 1; e_gc = gc_ok; m_rw = b[0];
      end else m_phase = 0;
    end else if (m_phase == 2) begin
      if (!busy) begin
        m_ack = 1; e_pull = 1; e_valid = 1; e_data = b;
      end else m_phase = 0;
    end
  endtask

  task automatic m_ack_end();
    e_pull = 0;
    if (m_ack && m_phase == 1) m_phase = m_rw ? 0 : 2;
    m_ack = 0;
  endtask

  task automatic send_start();
    sda_drv = 1; tick(P);
    scl_drv = 1; tick(P);
    sda_drv = 0; m_start(); tick(P);
    scl_drv = 0; tick(P);
  endtask

  task automatic send_stop();
    sda_drv = 0; tick(P);
    scl_drv = 1; tick(P);
    sda_drv = 1; m_stop(); tick(P);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(P);
      scl_drv = 1; tick(P);
      scl_drv = 0;
      if (i == 0) m_byte_end(b);
      tick(2);
    end
    sda_drv = 1; tick(P);
    scl_drv = 1; tick(P / 2);
    acked = !sda_bus;
    tick(P / 2);
    scl_drv = 0; m_ack_end(); tick(2);
  endtask

  initial begin
    bit a;
    int v0;
    tick(4);
    chk("R11 reset sda_pull", sda_pull, 0);
    chk("R11 reset rx_valid", rx_valid, 0);
    chk("R11 reset addressed", addressed, 0);
    rst = 0;
    tick(4);

    // R2 R3 R7 R10 R11: own write with two data bytes
    send_start();
    send_byte({7'h2D, 1'b0}, a); chk("R3 own write ack", a, 1);
    chk("R10 own flag", addressed, 1); chk("R10 own not gc", addressed_gc, 0);
    send_byte(8'hA5, a); chk("R7 data ack A5", a, 1);
    send_byte(8'h3C, a); chk("R7 data ack 3C", a, 1);
    send_stop(); tick(P);
    chk("R11 stop clears flag", addressed, 0);

    // R9 R2: wrong address then data is ignored
    send_start();
    send_byte({7'h2C, 1'b0}, a); chk("R2 wrong addr nack", a, 0);
    v0 = vcount;
    send_byte(8'hFF, a); chk("R9 ignored byte nack", a, 0);
    send_byte(8'h00, a); chk("R9 ignored byte nack 2", a, 0);
    chk("R9 no strobes", vcount - v0, 0);
    send_stop();

    // R5: broadcast handling
    send_start();
    send_byte(8'h00, a); chk("R5 gc disabled nack", a, 0);
    send_stop();
    gc_en = 1;
    send_start();
    send_byte(8'h00, a); chk("R5 gc write ack", a, 1);
    chk("R10 gc flag", addressed_gc, 1);
    send_byte(8'h81, a); chk("R7 gc data ack", a, 1);
    send_stop();
    send_start();
    send_byte(8'h01, a); chk("R5 gc read nack", a, 0);
    send_stop();

    // R8: own read
    send_start();
    send_byte({7'h2D, 1'b1}, a); chk("R8 read ack", a, 1);
    chk("R8 read flag", addressed, 1);
    send_stop();

    // R1: repeated start aborts
    send_start();
    send_byte({7'h2D, 1'b0}, a); chk("R1 pre ack", a, 1);
    send_byte(8'h55, a); chk("R1 data ack", a, 1);
    send_start();
    chk("R1 flag cleared by restart", addressed, 0);
    send_byte({7'h2C, 1'b0}, a); chk("R1 restart other addr nack", a, 0);
    send_stop();

    // R6: busy forces not-acknowledge
    busy = 1;
    send_start();
    send_byte({7'h2D, 1'b0}, a); chk("R6 busy addr nack", a, 0);
    send_stop();
    busy = 0;
    send_start();
    send_byte({7'h2D, 1'b0}, a); chk("R6 idle addr ack", a, 1);
    send_byte(8'h11, a); chk("R6 data ack", a, 1);
    busy = 1;
    send_byte(8'h22, a); chk("R6 busy data nack", a, 0);
    busy = 0;
    v0 = vcount;
    send_byte(8'h33, a); chk("R9 after nack skip", a, 0);
    chk("R9 no strobe after nack", vcount - v0, 0);
    send_stop();

    // R4: reserved and zero own addresses never match
    own = 7'h7A;
    send_start();
    send_byte({7'h7A, 1'b0}, a); chk("R4 reserved own nack", a, 0);
    send_stop();
    own = 7'h78;
    send_start();
    send_byte({7'h78, 1'b1}, a); chk("R4 reserved read nack", a, 0);
    send_stop();
    own = 7'h00; gc_en = 0;
    send_start();
    send_byte(8'h00, a); chk("R4 zero own nack", a, 0);
    send_stop();
    tick(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule